// File: doc/BRIEF.md
# Snooping Line Coherence Controller

This block holds the coherence state of a single cache line in a private cache that sits on a snooping bus. The protocol variant is fixed when the block is elaborated. Two flags select it: one adds an Owned state and one adds an Exclusive state. Together they give the MSI, MESI, MOSI and MOESI variants. A third flag chooses whether a write to a shared copy asks the bus for an upgrade or for a full read-exclusive. A variant with an Owned state but without upgrades is refused at elaboration, because a read-exclusive would overwrite the owner's dirty copy.

Three event sources feed the block:
- the processor side: read, write, software prefetch and hardware prefetch;
- the fill side: read fill, read-exclusive fill and upgrade acknowledge;
- the snoop side: requests from other bus agents.

Each cycle the block accepts at most one event and looks it up in the transition rules of the chosen variant. One cycle later it presents the bus command to issue, the new line state and three strobes: supply data, assert shared and illegal event.

The named states are Invalid, Shared, Exclusive, Owned and Modified. The named transitions are:
- miss-read and miss-write, which issue a bus request;
- read-hit and write-hit, which stay silent;
- fill-shared, fill-exclusive, fill-modified and upgrade-complete, on the fill side;
- snoop-share, snoop-supply, snoop-kill and flush, on the snoop side;
- the illegal transition.

Top module: `coh_line_ctrl`

## Requirements
- R1: The state is three bits {valid, writable, dirty}: Invalid=000, Shared=100, Exclusive=110, Owned=101, Modified=111. An active-low synchronous reset puts the line in Invalid, with all strobes low and bus command NONE. A variant without an Owned state never holds 101.
- R2: At most one event is accepted per cycle, with priority snoop over fill over processor. Its results appear on the outputs one cycle after acceptance, together with `evt_done`. With no event, `evt_done`, the strobes and the bus command are zero and the state is held.
- R3: Processor op codes are read=0, write=1, software prefetch=2 and hardware prefetch=3. Bus commands are NONE=0, READ=1, READEX=2 and UPGRADE=3. On an Invalid line, a read or either prefetch issues READ and a write issues READEX (miss-read, miss-write). The state stays Invalid until the fill arrives.
- R4: A processor write to a Shared or Owned line issues UPGRADE when upgrades are enabled and READEX otherwise. The state is unchanged until the acknowledge.
- R5: A processor write to Exclusive or Modified moves the line to Modified with no bus command (write-hit). A processor read to any valid state issues nothing and keeps the state (read-hit).
- R6: Fill op codes are read fill=0, read-exclusive fill=1 and upgrade acknowledge=2. A read fill on Invalid goes to Exclusive when the variant has Exclusive and `rsp_shared` is low. In every other case it goes to Shared.
- R7: A read-exclusive fill on Invalid goes to Modified. On Shared or Owned, the write acknowledge goes to Modified: that acknowledge is code 2 with upgrades enabled and code 1 without.
- R8: Snoop op codes are read=0, readex=1, upgrade=2, invalidate=3 and write-invalidate=4. A snooped read on Exclusive pulses `assert_shared` and moves to Shared. On Shared it pulses `assert_shared` only in variants with Exclusive, and the state is held.
- R9: A snooped read on Modified pulses `supply_data` and moves to Owned, or to Shared in variants without Owned. On Owned it supplies and stays Owned.
- R10: A snooped readex on Modified or Owned supplies and invalidates. On Shared or Exclusive it invalidates without supplying. A snooped upgrade on Shared or Owned invalidates without supplying. Snooped read, readex or upgrade on Invalid changes nothing.
- R11: A snooped invalidate or write-invalidate moves the line to Invalid from every state.
- R12: Any state and event pair not listed above pulses `illegal_evt`. The state, the bus command and the data strobes are left untouched. Examples are a prefetch to a valid line and an acknowledge that matches no outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor request present |
| proc_op | input | 2 | Processor op code |
| rsp_valid | input | 1 | Fill or acknowledge present |
| rsp_op | input | 2 | Fill op code |
| rsp_shared | input | 1 | Another cache holds the line (fill side) |
| snp_valid | input | 1 | Snooped bus request present |
| snp_op | input | 3 | Snoop op code |
| line_state | output | 3 | Current state {valid, writable, dirty} |
| bus_cmd | output | 2 | Bus command to issue |
| supply_data | output | 1 | This cache must drive the line data |
| assert_shared | output | 1 | Drive the bus shared indication |
| illegal_evt | output | 1 | Event undefined for the current state |
| evt_done | output | 1 | Outputs reflect an event accepted last cycle |

## Verification
The checker relies on three facts that hold for any input sequence:
- every accepted event produces `evt_done` one cycle later;
- strobes only accompany `evt_done`;
- a bus command or an illegal event never changes the state.

It therefore needs no protocol-level assumptions about the inputs. Op codes outside the defined ranges land in the illegal path, so the stimulus drives only defined codes except where it probes R12 on purpose. The bench walks each line through request, fill and snoop sequences in the order a real bus would produce them. It raises several valid inputs together only in the priority scenario.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'b000,
        ST_S = 3'b100,
        ST_E = 3'b110,
        ST_O = 3'b101,
        ST_M = 3'b111
    } line_st_e;

    localparam int unsigned ST_W     = 3;
    localparam int unsigned BIT_DIRTY = 0;

    typedef enum logic [1:0] {
        PR_READ  = 2'd0,
        PR_WRITE = 2'd1,
        PR_SWPF  = 2'd2,
        PR_HWPF  = 2'd3
    } proc_op_e;

    typedef enum logic [1:0] {
        RS_READ = 2'd0,
        RS_RDEX = 2'd1,
        RS_UPG  = 2'd2,
        RS_RSVD = 2'd3
    } rsp_op_e;

    typedef enum logic [2:0] {
        SN_READ  = 3'd0,
        SN_RDEX  = 3'd1,
        SN_UPG   = 3'd2,
        SN_INV   = 3'd3,
        SN_WRINV = 3'd4
    } snp_op_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_READ = 2'd1,
        BC_RDEX = 2'd2,
        BC_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_SNOOP = 2'd1,
        EV_RESP  = 2'd2,
        EV_PROC  = 2'd3
    } ev_src_e;

    typedef struct packed {
        ev_src_e    src;
        logic [2:0] op;
        logic       shared;
    } ev_t;

    typedef struct packed {
        line_st_e nxt;
        bus_cmd_e cmd;
        logic     supply;
        logic     shr;
        logic     bad;
    } act_t;

endpackage

// File: rtl/coh_evt_arb.sv
module coh_evt_arb
    import coh_pkg::*;
(
    input  logic       proc_valid,
    input  logic [1:0] proc_op,
    input  logic       rsp_valid,
    input  logic [1:0] rsp_op,
    input  logic       rsp_shared,
    input  logic       snp_valid,
    input  logic [2:0] snp_op,
    output ev_t        ev
);
    always_comb begin
        ev = '{src: EV_NONE, op: 3'd0, shared: 1'b0};
        if (snp_valid) begin
            ev.src = EV_SNOOP;
            ev.op  = snp_op;
        end else if (rsp_valid) begin
            ev.src    = EV_RESP;
            ev.op     = {1'b0, rsp_op};
            ev.shared = rsp_shared;
        end else if (proc_valid) begin
            ev.src = EV_PROC;
            ev.op  = {1'b0, proc_op};
        end
    end
endmodule

// File: rtl/coh_local_rules.sv
module coh_local_rules
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED    = 1'b1,
    parameter bit HAS_EXCL     = 1'b1,
    parameter bit USE_UPGRADES = 1'b1
) (
    input  line_st_e   cur,
    input  logic       is_resp,
    input  logic [1:0] op,
    input  logic       shared,
    output act_t       act
);
    localparam bus_cmd_e WR_SHARED_CMD = USE_UPGRADES ? BC_UPG : BC_RDEX;
    localparam rsp_op_e  WR_SHARED_ACK = USE_UPGRADES ? RS_UPG : RS_RDEX;

    proc_op_e pop;
    rsp_op_e  rop;

    assign pop = proc_op_e'(op);
    assign rop = rsp_op_e'(op);

    always_comb begin
        act = '{nxt: cur, cmd: BC_NONE, supply: 1'b0, shr: 1'b0, bad: 1'b0};
        if (!is_resp) begin
            unique case (cur)
                ST_I: begin
                    if (pop == PR_WRITE) act.cmd = BC_RDEX;
                    else                 act.cmd = BC_READ;
                end
                ST_S: begin
                    if (pop == PR_READ)       act.cmd = BC_NONE;
                    else if (pop == PR_WRITE) act.cmd = WR_SHARED_CMD;
                    else                      act.bad = 1'b1;
                end
                ST_E: begin
                    if (!HAS_EXCL)            act.bad = 1'b1;
                    else if (pop == PR_READ)  act.cmd = BC_NONE;
                    else if (pop == PR_WRITE) act.nxt = ST_M;
                    else                      act.bad = 1'b1;
                end
                ST_O: begin
                    if (!HAS_OWNED)           act.bad = 1'b1;
                    else if (pop == PR_READ)  act.cmd = BC_NONE;
                    else if (pop == PR_WRITE) act.cmd = WR_SHARED_CMD;
                    else                      act.bad = 1'b1;
                end
                ST_M: begin
                    if (pop == PR_SWPF || pop == PR_HWPF) act.bad = 1'b1;
                end
                default: act.bad = 1'b1;
            endcase
        end else begin
            unique case (cur)
                ST_I: begin
                    if (rop == RS_READ)
                        act.nxt = (HAS_EXCL && !shared) ? ST_E : ST_S;
                    else if (rop == RS_RDEX)
                        act.nxt = ST_M;
                    else
                        act.bad = 1'b1;
                end
                ST_S: begin
                    if (rop == WR_SHARED_ACK) act.nxt = ST_M;
                    else                      act.bad = 1'b1;
                end
                ST_O: begin
                    if (HAS_OWNED && rop == WR_SHARED_ACK) act.nxt = ST_M;
                    else                                   act.bad = 1'b1;
                end
                default: act.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/coh_snoop_rules.sv
module coh_snoop_rules
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED    = 1'b1,
    parameter bit HAS_EXCL     = 1'b1,
    parameter bit USE_UPGRADES = 1'b1
) (
    input  line_st_e   cur,
    input  logic [2:0] op,
    output act_t       act
);
    localparam line_st_e M_ON_READ = HAS_OWNED ? ST_O : ST_S;

    snp_op_e sop;
    logic    flush;

    assign sop   = snp_op_e'(op);
    assign flush = (sop == SN_INV) || (sop == SN_WRINV);

    always_comb begin
        act = '{nxt: cur, cmd: BC_NONE, supply: 1'b0, shr: 1'b0, bad: 1'b0};
        if (flush) begin
            act.nxt = ST_I;
        end else begin
            unique case (cur)
                ST_I: begin
                    if (sop == SN_READ || sop == SN_RDEX) act.nxt = ST_I;
                    else if (sop == SN_UPG && USE_UPGRADES) act.nxt = ST_I;
                    else act.bad = 1'b1;
                end
                ST_S: begin
                    if (sop == SN_READ) act.shr = HAS_EXCL;
                    else if (sop == SN_RDEX) act.nxt = ST_I;
                    else if (sop == SN_UPG && USE_UPGRADES) act.nxt = ST_I;
                    else act.bad = 1'b1;
                end
                ST_E: begin
                    if (!HAS_EXCL) act.bad = 1'b1;
                    else if (sop == SN_READ) begin
                        act.shr = 1'b1;
                        act.nxt = ST_S;
                    end else if (sop == SN_RDEX) act.nxt = ST_I;
                    else act.bad = 1'b1;
                end
                ST_O: begin
                    if (!HAS_OWNED) act.bad = 1'b1;
                    else if (sop == SN_READ) act.supply = 1'b1;
                    else if (sop == SN_RDEX) begin
                        act.supply = 1'b1;
                        act.nxt    = ST_I;
                    end else if (sop == SN_UPG) act.nxt = ST_I;
                    else act.bad = 1'b1;
                end
                ST_M: begin
                    if (sop == SN_READ) begin
                        act.supply = 1'b1;
                        act.nxt    = M_ON_READ;
                    end else if (sop == SN_RDEX) begin
                        act.supply = 1'b1;
                        act.nxt    = ST_I;
                    end else act.bad = 1'b1;
                end
                default: act.bad = 1'b1;
            endcase
        end
        if (act.bad) act.nxt = cur;
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED    = 1'b1,
    parameter bit HAS_EXCL     = 1'b1,
    parameter bit USE_UPGRADES = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_valid,
    input  logic [1:0] proc_op,
    input  logic       rsp_valid,
    input  logic [1:0] rsp_op,
    input  logic       rsp_shared,
    input  logic       snp_valid,
    input  logic [2:0] snp_op,
    output logic [2:0] line_state,
    output logic [1:0] bus_cmd,
    output logic       supply_data,
    output logic       assert_shared,
    output logic       illegal_evt,
    output logic       evt_done
);
    generate
        if (HAS_OWNED && !USE_UPGRADES) begin : g_bad_cfg
            $error("owned-state variant requires upgrade requests");
        end
    endgenerate

    ev_t      ev;
    act_t     act_loc;
    act_t     act_snp;
    act_t     act;
    line_st_e st_q;
    bus_cmd_e cmd_q;
    logic     supply_q;
    logic     shr_q;
    logic     bad_q;
    logic     done_q;
    logic     take;

    coh_evt_arb u_arb (
        .proc_valid (proc_valid),
        .proc_op    (proc_op),
        .rsp_valid  (rsp_valid),
        .rsp_op     (rsp_op),
        .rsp_shared (rsp_shared),
        .snp_valid  (snp_valid),
        .snp_op     (snp_op),
        .ev         (ev)
    );

    coh_local_rules #(
        .HAS_OWNED    (HAS_OWNED),
        .HAS_EXCL     (HAS_EXCL),
        .USE_UPGRADES (USE_UPGRADES)
    ) u_local (
        .cur     (st_q),
        .is_resp (ev.src == EV_RESP),
        .op      (ev.op[1:0]),
        .shared  (ev.shared),
        .act     (act_loc)
    );

    coh_snoop_rules #(
        .HAS_OWNED    (HAS_OWNED),
        .HAS_EXCL     (HAS_EXCL),
        .USE_UPGRADES (USE_UPGRADES)
    ) u_snoop (
        .cur (st_q),
        .op  (ev.op),
        .act (act_snp)
    );

    assign take = (ev.src != EV_NONE);
    assign act  = (ev.src == EV_SNOOP) ? act_snp : act_loc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= ST_I;
        else if (take) st_q <= act.bad ? st_q : act.nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            cmd_q    <= BC_NONE;
            supply_q <= 1'b0;
            shr_q    <= 1'b0;
            bad_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            cmd_q    <= act.bad ? BC_NONE : act.cmd;
            supply_q <= act.supply & ~act.bad;
            shr_q    <= act.shr & ~act.bad;
            bad_q    <= act.bad;
            done_q   <= 1'b1;
        end
    end

    assign line_state    = st_q;
    assign bus_cmd       = cmd_q;
    assign supply_data   = supply_q;
    assign assert_shared = shr_q;
    assign illegal_evt   = bad_q;
    assign evt_done      = done_q;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
    parameter bit HAS_OWNED = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       proc_valid,
    input logic       rsp_valid,
    input logic       snp_valid,
    input logic [2:0] snp_op,
    input logic [2:0] line_state,
    input logic [1:0] bus_cmd,
    input logic       supply_data,
    input logic       assert_shared,
    input logic       illegal_evt,
    input logic       evt_done
);
    logic any_ev;
    assign any_ev = proc_valid | rsp_valid | snp_valid;

    assert_no_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_OWNED || line_state != 3'b101));

    assert_event_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_ev |=> evt_done);

    assert_strobe_needs_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_data || assert_shared || illegal_evt || bus_cmd != 2'd0) |-> evt_done);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> $stable(line_state));

    assert_request_holds_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> $stable(line_state));

    assert_supply_from_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |-> $past(line_state[0]));

    assert_flush_to_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_op == 3'd3 || snp_op == 3'd4)) |=> line_state == 3'b000);

    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_evt |-> ($stable(line_state) && bus_cmd == 2'd0 && !supply_data));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.HAS_OWNED(HAS_OWNED)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_valid    (proc_valid),
    .rsp_valid     (rsp_valid),
    .snp_valid     (snp_valid),
    .snp_op        (snp_op),
    .line_state    (line_state),
    .bus_cmd       (bus_cmd),
    .supply_data   (supply_data),
    .assert_shared (assert_shared),
    .illegal_evt   (illegal_evt),
    .evt_done      (evt_done)
);

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       proc_valid = 1'b0;
    logic [1:0] proc_op = 2'd0;
    logic       rsp_valid = 1'b0;
    logic [1:0] rsp_op = 2'd0;
    logic       rsp_shared = 1'b0;
    logic       snp_valid = 1'b0;
    logic [2:0] snp_op = 3'd0;

    logic [2:0] st_a, st_b;
    logic [1:0] cmd_a, cmd_b;
    logic       sup_a, sup_b, shr_a, shr_b, bad_a, bad_b, done_a, done_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    coh_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_op(proc_op),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_shared(rsp_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .line_state(st_a), .bus_cmd(cmd_a),
        .supply_data(sup_a), .assert_shared(shr_a), .illegal_evt(bad_a), .evt_done(done_a)
    );

    coh_line_ctrl #(.HAS_OWNED(1'b0), .HAS_EXCL(1'b0), .USE_UPGRADES(1'b0)) dut_msi_i (
        .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_op(proc_op),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_shared(rsp_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .line_state(st_b), .bus_cmd(cmd_b),
        .supply_data(sup_b), .assert_shared(shr_b), .illegal_evt(bad_b), .evt_done(done_b)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive inputs on a falling edge, sample after the accepting edge
    task automatic fire(input bit pv, input int po, input bit rv, input int ro,
                        input bit rs, input bit sv, input int so);
        @(negedge clk);
        proc_valid = pv; proc_op = 2'(po);
        rsp_valid = rv;  rsp_op = 2'(ro); rsp_shared = rs;
        snp_valid = sv;  snp_op = 3'(so);
        @(negedge clk);
        proc_valid = 1'b0; rsp_valid = 1'b0; snp_valid = 1'b0; rsp_shared = 1'b0;
    endtask

    task automatic prc(input int op);              fire(1, op, 0, 0, 0, 0, 0); endtask
    task automatic rsp(input int op, input bit s); fire(0, 0, 1, op, s, 0, 0); endtask
    task automatic snp(input int op);              fire(0, 0, 0, 0, 0, 1, op); endtask

    task automatic t_reset;
        chk("R1 reset state", st_a, 0);
        chk("R1 reset cmd", cmd_a, 0);
        chk("R1 reset strobes", {sup_a, shr_a, bad_a, done_a}, 0);
    endtask

    task automatic t_msi_variant;
        prc(0);    chk("R3 msi miss read cmd", cmd_b, 1);
        rsp(0, 0); chk("R6 msi fill to shared", st_b, 3'b100);
                   chk("R6 moesi fill to exclusive", st_a, 3'b110);
        snp(0);    chk("R8 msi shared no assert", shr_b, 0);
                   chk("R8 msi stays shared", st_b, 3'b100);
                   chk("R8 moesi exclusive asserts", shr_a, 1);
                   chk("R8 moesi exclusive to shared", st_a, 3'b100);
        prc(1);    chk("R4 msi write shared readex", cmd_b, 2);
                   chk("R4 moesi write shared upgrade", cmd_a, 3);
        rsp(1, 0); chk("R7 msi readex ack to modified", st_b, 3'b111);
        snp(0);    chk("R9 msi supply", sup_b, 1);
                   chk("R9 msi modified to shared", st_b, 3'b100);
        snp(3);    chk("R11 msi invalidate", st_b, 0);
                   chk("R11 moesi invalidate", st_a, 0);
    endtask

    task automatic t_owned_path;
        prc(0);    chk("R3 read miss cmd", cmd_a, 1);
                   chk("R3 read miss holds invalid", st_a, 0);
        rsp(0, 0); chk("R6 clean fill exclusive", st_a, 3'b110);
        prc(0);    chk("R5 read hit no cmd", cmd_a, 0);
                   chk("R5 read hit holds", st_a, 3'b110);
        prc(1);    chk("R5 write hit exclusive", st_a, 3'b111);
                   chk("R5 write hit no cmd", cmd_a, 0);
        snp(0);    chk("R9 modified supply", sup_a, 1);
                   chk("R9 modified to owned", st_a, 3'b101);
        snp(0);    chk("R9 owned supply", sup_a, 1);
                   chk("R9 owned stays", st_a, 3'b101);
        prc(1);    chk("R4 owned write upgrade", cmd_a, 3);
                   chk("R4 owned holds", st_a, 3'b101);
        rsp(2, 0); chk("R7 upgrade ack owned", st_a, 3'b111);
        snp(1);    chk("R10 readex on modified supply", sup_a, 1);
                   chk("R10 readex on modified invalid", st_a, 0);
    endtask

    task automatic t_shared_path;
        prc(2);    chk("R3 swpf miss read", cmd_a, 1);
        rsp(0, 1); chk("R6 shared fill", st_a, 3'b100);
        snp(0);    chk("R8 shared asserts", shr_a, 1);
                   chk("R8 shared holds", st_a, 3'b100);
        prc(1);    chk("R4 shared write upgrade", cmd_a, 3);
        snp(2);    chk("R10 upgrade snoop kills shared", st_a, 0);
                   chk("R10 upgrade snoop no supply", sup_a, 0);
        snp(2);    chk("R10 upgrade snoop on invalid", {bad_a, sup_a, shr_a, st_a}, 0);
        snp(1);    chk("R10 readex snoop on invalid", {bad_a, sup_a, st_a}, 0);
    endtask

    task automatic t_exclusive_kill;
        prc(3);    chk("R3 hwpf miss read", cmd_a, 1);
        rsp(0, 0); chk("R6 hwpf fill exclusive", st_a, 3'b110);
        snp(1);    chk("R10 readex on exclusive", st_a, 0);
                   chk("R10 exclusive no supply", sup_a, 0);
        prc(1);    chk("R3 write miss readex", cmd_a, 2);
        rsp(1, 0); chk("R7 readex fill modified", st_a, 3'b111);
        snp(4);    chk("R11 write-invalidate from modified", st_a, 0);
    endtask

    task automatic t_illegal;
        rsp(2, 0); chk("R12 stray ack flag", bad_a, 1);
                   chk("R12 stray ack state", st_a, 0);
        prc(0); rsp(0, 0);
        prc(2);    chk("R12 prefetch hit flag", bad_a, 1);
                   chk("R12 prefetch hit state", st_a, 3'b110);
                   chk("R12 prefetch hit cmd", cmd_a, 0);
    endtask

    task automatic t_priority;
        // line is Exclusive here
        fire(1, 1, 1, 0, 0, 1, 3);
        chk("R2 snoop wins state", st_a, 0);
        chk("R2 snoop wins cmd", cmd_a, 0);
        chk("R2 done", done_a, 1);
        @(negedge clk);
        chk("R2 idle done low", done_a, 0);
        prc(0); rsp(0, 1);
        fire(1, 1, 1, 1, 0, 0, 0);
        chk("R2 fill beats request", bad_a, 1);
        chk("R2 fill beats request cmd", cmd_a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msi_variant();
        t_owned_path();
        t_shared_path();
        t_exclusive_kill();
        t_illegal();
        t_priority();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule